// File: doc/BRIEF.md
# GPIO Controller with Change Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 lines. A processor reaches it through a single-cycle 32-bit register port with an address, a write strobe, write data and combinational read data. Each line can be an input or an output. One data word drives the output values and reports the line levels. A write-mask word limits which output bits a data write may change.

Every line has a change-detect flag. Any rising or falling transition on the synchronized input sets the flag, and software clears it by writing a one to it. The controller raises a single interrupt towards a parent controller whenever a line has its change flag set and its enable bit set. The number of implemented lines is the parameter `LINES`. Register bits above that count read as zero.

Top module: `gpio_chg_top`

## Requirements
- R1: After reset, the direction, output, enable and change words are all zero. The write-mask word is all ones on implemented lines. `pinOutEn`, `pinOut` and `irqOut` are zero.
- R2: The direction word sits at byte offset 0x00. A 1 in bit i makes line i an output, so `pinOutEn[i]` follows that bit. The word reads back as written.
- R3: A write to the data word at offset 0x04 changes `pinOut[i]` only where bit i of the write-mask word at offset 0x10 is 1. Other output bits keep their value.
- R4: A read of offset 0x04 returns, for each line, its driven output value if the line is an output. If the line is an input, the read returns the input pin after a two-flop synchronizer, so a pin change first appears in the read after the second rising clock edge.
- R5: Both edges are detected. A pin transition sets bit i of the change word at offset 0x0C on the third rising clock edge after the change. The bit is not set before that edge.
- R6: Writing to offset 0x0C clears each change bit whose write-data bit is 1 and leaves the other change bits unchanged.
- R7: If a new transition sets a change bit on the same clock edge as a clear write to that bit, the bit stays set.
- R8: `irqOut` is 1 exactly when some line has both its change bit and its enable bit (offset 0x08) set. Clearing all enables drops `irqOut` on the next edge.
- R9: The trigger-type word at offset 0x14 reads all ones on implemented lines, meaning both-edge. Writes to it have no effect. Reads of unmapped offsets return zero.
- R10: Bits at and above `LINES` read as zero in every register, even after all-ones writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| pinIn | input | LINES | Asynchronous input pin levels |
| pinOut | output | LINES | Output pin values |
| pinOutEn | output | LINES | Output enable per line (1 = drive) |
| irqOut | output | 1 | Combined change interrupt |

## Verification
Two things can land on the same clock edge: a software clear of a change bit and a fresh transition on that same line. The bench first sets a bit, then toggles the pin so that the edge reaches the change word exactly as the clear write is clocked. It expects the bit to survive, and expects a second clear without a transition to remove it. The random phase mixes pin changes, masked data writes and partial clears. Every read is compared with a bench model built from the offsets and timing in the requirements.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam logic [7:0] OFS_DIR  = 8'h00;
  localparam logic [7:0] OFS_DATA = 8'h04;
  localparam logic [7:0] OFS_EN   = 8'h08;
  localparam logic [7:0] OFS_CHG  = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h10;
  localparam logic [7:0] OFS_TYPE = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIR, SEL_DATA, SEL_EN, SEL_CHG, SEL_MASK, SEL_TYPE
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrData;
    logic    wrEn;
    logic    wrAck;
    logic    wrMask;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobes_t          strb
);
  regSel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if      (busAddr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
    else if (busAddr == ADDR_W'(OFS_DATA)) sel = SEL_DATA;
    else if (busAddr == ADDR_W'(OFS_EN))   sel = SEL_EN;
    else if (busAddr == ADDR_W'(OFS_CHG))  sel = SEL_CHG;
    else if (busAddr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
    else if (busAddr == ADDR_W'(OFS_TYPE)) sel = SEL_TYPE;
  end

  always_comb begin
    strb.rdSel  = sel;
    strb.wrDir  = busWrEn && (sel == SEL_DIR);
    strb.wrData = busWrEn && (sel == SEL_DATA);
    strb.wrEn   = busWrEn && (sel == SEL_EN);
    strb.wrAck  = busWrEn && (sel == SEL_CHG);
    strb.wrMask = busWrEn && (sel == SEL_MASK);
  end

  // R2: at most one register is written per cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrData, strb.wrEn, strb.wrAck, strb.wrMask}));
endmodule

// File: rtl/gpio_chg_dp.sv
module gpio_chg_dp
  import gpio_chg_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [31:0]      busWrData,
  input  logic [LINES-1:0] pinIn,
  output logic [31:0]      busRdData,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOutEn,
  output logic             irqOut
);
  localparam logic [LINES-1:0] ALL_ONES = {LINES{1'b1}};

  logic [LINES-1:0] wd;
  logic [LINES-1:0] dirReg, outReg, enReg, chgReg, maskReg;
  logic [LINES-1:0] syncA, syncB, prevIn;
  logic [LINES-1:0] edgeVec, ackVec, lineLvl;

  assign wd      = busWrData[LINES-1:0];
  assign edgeVec = syncB ^ prevIn;
  assign ackVec  = strb.wrAck ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      enReg   <= '0;
      chgReg  <= '0;
      maskReg <= ALL_ONES;
      syncA   <= '0;
      syncB   <= '0;
      prevIn  <= '0;
    end else begin
      syncA  <= pinIn;
      syncB  <= syncA;
      prevIn <= syncB;
      if (strb.wrDir)  dirReg  <= wd;
      if (strb.wrData) outReg  <= (outReg & ~maskReg) | (wd & maskReg);
      if (strb.wrEn)   enReg   <= wd;
      if (strb.wrMask) maskReg <= wd;
      chgReg <= (chgReg & ~ackVec) | edgeVec;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_lvl
    assign lineLvl[i] = dirReg[i] ? outReg[i] : syncB[i];
  end

  always_comb begin
    case (strb.rdSel)
      SEL_DIR:  busRdData = 32'(dirReg);
      SEL_DATA: busRdData = 32'(lineLvl);
      SEL_EN:   busRdData = 32'(enReg);
      SEL_CHG:  busRdData = 32'(chgReg);
      SEL_MASK: busRdData = 32'(maskReg);
      SEL_TYPE: busRdData = 32'(ALL_ONES);
      default:  busRdData = '0;
    endcase
  end

  assign pinOut   = outReg;
  assign pinOutEn = dirReg;
  assign irqOut   = |(chgReg & enReg);

  // R5, R7: a detected transition always leaves its change bit set
  a_r7_edge_sets_bit: assert property (@(posedge clk) disable iff (!rstN)
    (edgeVec != '0) |=> ((chgReg & $past(edgeVec)) == $past(edgeVec)));

  // R6: acknowledged bits without a coincident edge are cleared
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAck |=> ((chgReg & $past(wd & ~edgeVec)) == '0));

  // R3: output bits outside the write mask hold across a data write
  a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (((outReg ^ $past(outReg)) & ~$past(maskReg)) == '0));
endmodule

// File: rtl/gpio_chg_top.sv
module gpio_chg_top
  import gpio_chg_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOutEn,
  output logic              irqOut
);
  strobes_t strb;

  gpio_chg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  gpio_chg_dp #(.LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData), .pinIn(pinIn),
    .busRdData(busRdData), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  // R8: clearing every enable removes the interrupt on the next edge
  a_r8_disable_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_EN) && busWrData[LINES-1:0] == '0) |=> !irqOut);

  // R1: no output drive in the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (pinOutEn == '0 && pinOut == '0 && !irqOut));

  if (LINES < 32) begin : g_upper
    // R10: unimplemented bits always read zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
      busRdData[31:LINES] == '0);
  end
endmodule

// File: tb/tb_gpio_chg_top.sv
module tb_gpio_chg_top;
  localparam int CLK_P = 10;
  localparam int N     = 24;
  localparam int AW    = 5;
  localparam logic [31:0] M = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] busAddr;
  logic          busWrEn;
  logic [31:0]   busWrData;
  logic [31:0]   busRdData;
  logic [N-1:0]  pinIn;
  logic [N-1:0]  pinOut, pinOutEn;
  logic          irqOut;

  int total = 0;
  int bad   = 0;

  logic [31:0] eDir, eOut, eEn, eChg, eMask, ePins;

  always #(CLK_P/2) clk = ~clk;

  gpio_chg_top #(.LINES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lvl();
    return ((eDir & eOut) | (~eDir & ePins)) & M;
  endfunction

  function automatic logic [31:0] expIrq();
    return {31'd0, |(eChg & eEn)};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    busAddr = a[AW-1:0]; busWrEn = 1'b1; busWrData = d;
    @(posedge clk);
    case (a)
      8'h00: eDir  = d & M;
      8'h04: eOut  = ((eOut & ~eMask) | (d & eMask)) & M;
      8'h08: eEn   = d & M;
      8'h0C: eChg  = eChg & ~d;
      8'h10: eMask = d & M;
      default: ;
    endcase
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    busAddr = a[AW-1:0]; busWrEn = 1'b0;
    #1 d = busRdData;
  endtask

  task automatic setPins(logic [31:0] v);
    eChg = eChg | ((ePins ^ v) & M);
    ePins = v & M;
    pinIn = v[N-1:0];
    idle(3);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rstN = 1'b0; busAddr = '0; busWrEn = 1'b0; busWrData = '0; pinIn = '0;
    eDir = 0; eOut = 0; eEn = 0; eChg = 0; eMask = M; ePins = 0;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rdReg(8'h00, r); check("R1 dir", r, 0);
    rdReg(8'h04, r); check("R1 data", r, 0);
    rdReg(8'h08, r); check("R1 enable", r, 0);
    rdReg(8'h0C, r); check("R1 change", r, 0);
    rdReg(8'h10, r); check("R1 wmask", r, M);
    check("R1 pins", {pinOutEn, pinOut}, 0);
    check("R1 irq", {31'd0, irqOut}, 0);
    // R9 type and unmapped
    rdReg(8'h14, r); check("R9 type", r, M);
    wrReg(8'h14, 32'h0);
    rdReg(8'h14, r); check("R9 type write ignored", r, M);
    rdReg(8'h18, r); check("R9 unmapped", r, 0);

    // R2 and R10 direction
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdReg(8'h00, r); check("R10 dir upper", r, M);
    check("R2 outEn", 32'(pinOutEn), M);
    wrReg(8'h00, 32'h0000_FF0F);
    check("R2 outEn pattern", 32'(pinOutEn), 32'h0000_FF0F);

    // R3 masked data write
    wrReg(8'h10, 32'h00F0_F0F0);
    wrReg(8'h04, 32'hFFFF_FFFF);
    check("R3 masked write", 32'(pinOut), 32'h00F0_F0F0);
    wrReg(8'h10, 32'hFFFF_FFFF);
    wrReg(8'h04, 32'h0000_0F05);
    check("R3 full write", 32'(pinOut), 32'h0000_0F05);

    // R4 latency of input read, R5 change latency
    pinIn = 24'h123456;
    eChg = eChg | ((ePins ^ 32'h123456) & M);
    @(negedge clk);
    rdReg(8'h04, r); check("R4 data one edge", r, lvl());
    ePins = 32'h123456;
    @(negedge clk);
    rdReg(8'h04, r); check("R4 data two edges", r, lvl());
    rdReg(8'h0C, r); check("R5 change early", r, 0);
    @(negedge clk);
    rdReg(8'h0C, r); check("R5 change set", r, 32'h123456);

    // R6 partial clear
    wrReg(8'h0C, 32'h0000_3050);
    rdReg(8'h0C, r); check("R6 partial clear", r, eChg);
    wrReg(8'h0C, 32'hFFFF_FFFF);
    rdReg(8'h0C, r); check("R6 full clear", r, 0);
    // falling edge on bit 1 (R5 both edges)
    setPins(32'h123454);
    rdReg(8'h0C, r); check("R5 falling edge", r, 32'h2);

    // R7 collision: bit 1 set; toggle again, clear lands on same edge
    pinIn = 24'h123456; ePins = 32'h123456;
    @(negedge clk);
    @(negedge clk);
    busAddr = 5'h0C; busWrEn = 1'b1; busWrData = 32'h2;
    @(posedge clk); @(negedge clk); busWrEn = 1'b0;
    rdReg(8'h0C, r); check("R7 edge wins over clear", r, 32'h2);
    wrReg(8'h0C, 32'h2);
    rdReg(8'h0C, r); check("R7 later clear", r, 0);
    eChg = 0;

    // R8 interrupt
    setPins(32'h123457);
    check("R8 irq masked", {31'd0, irqOut}, 0);
    wrReg(8'h08, 32'h1);
    check("R8 irq enabled", {31'd0, irqOut}, 1);
    wrReg(8'h08, 32'h0);
    check("R8 irq disabled", {31'd0, irqOut}, 0);
    wrReg(8'h08, 32'hFFFF_FFFF);
    rdReg(8'h08, r); check("R10 enable upper", r, M);
    wrReg(8'h0C, 32'hFFFF_FFFF);
    check("R8 irq after clear", {31'd0, irqOut}, 0);

    // random phase
    for (int it = 0; it < 60; it++) begin
      wrReg(8'h00, $urandom);
      wrReg(8'h10, $urandom);
      wrReg(8'h04, $urandom);
      wrReg(8'h08, $urandom);
      setPins($urandom);
      check("R3 random pinOut", 32'(pinOut), eOut);
      check("R2 random outEn", 32'(pinOutEn), eDir);
      rdReg(8'h04, r); check("R4 random data", r, lvl());
      rdReg(8'h0C, r); check("R5 random change", r, eChg);
      check("R8 random irq", {31'd0, irqOut}, expIrq());
      wrReg(8'h0C, $urandom);
      rdReg(8'h0C, r); check("R6 random clear", r, eChg);
      check("R8 random irq after clear", {31'd0, irqOut}, expIrq());
    end

    summary();
    $finish;
  end
endmodule